// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two signals of an incremental encoder into a position count. The count lives between zero and a programmable limit and wraps at either end. In simple mode only input A matters, and each qualifying edge on it adds one. In quadrature mode both inputs are used. Which input moved, and the level held on the other input, decide whether a step counts up or down.

A two-bit edge selector picks which transitions count: rising only, falling only, or both. The encoder inputs are asynchronous, so they pass through a synchroniser chain. A change is detected by comparing each synchronised level with its value one clock earlier.

Mode, edge selection and limit are captured only while the counter is disabled. They can therefore be rewritten safely between runs. In quadrature mode, a clock in which both inputs change together cannot be decoded, so it raises a sticky error flag and leaves the count alone.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `count` is 0, `dir_up` is 0 and `err_flag` is 0.
- R2: With `cfg_quad`=0, each qualifying edge on `enc_a` adds one to the count and sets `dir_up` to 1. Any activity on `enc_b` leaves the count unchanged.
- R3: `cfg_edge` selects which transitions count: 2'b00 counts rising edges only, 2'b01 counts falling edges only, and 2'b10 or 2'b11 counts both.
- R4: In quadrature mode with rising edges selected, a rise of A counts down when B is high and up when B is low. A rise of B counts up when A is high and down when A is low. Falling edges cause no count.
- R5: In quadrature mode with falling edges selected, a fall of A counts up when B is high and down when B is low. A fall of B counts down when A is high and up when A is low. Rising edges cause no count.
- R6: In quadrature mode with both edges selected, every single-input transition makes exactly one step, following the R4 and R5 rules.
- R7: A step up from a count equal to or above the limit gives 0. A step down from 0 gives the limit.
- R8: In quadrature mode, a clock in which both synchronised inputs change leaves the count unchanged and sets `err_flag`. The flag then stays set until a clear.
- R9: `clear` sets the count to 0 and `err_flag` to 0 on the next clock, and takes priority over any step.
- R10: `cfg_quad`, `cfg_edge` and `cfg_preset` are captured only on clocks where `enable` is low. Changes made while enabled have no effect.
- R11: No step is taken while `enable` is low, nor on the first clock after it rises. Input changes made while disabled are never counted.
- R12: An input change present at rising clock edge k appears on `count` after rising edge k+2, and not before.
- R13: `dir_up` holds the direction of the most recent step (1 = up, 0 = down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting enable; configuration is captured while low |
| clear | input | 1 | Synchronous clear of count and error flag |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| cfg_quad | input | 1 | 1 = quadrature mode, 0 = simple mode on A |
| cfg_edge | input | 2 | Active edge: 00 rising, 01 falling, 1x both |
| cfg_preset | input | CNT_W | Upper limit of the count |
| count | output | CNT_W | Current position |
| dir_up | output | 1 | Direction of the last step |
| err_flag | output | 1 | Sticky simultaneous-change error |

## Verification
The state that matters is held in a few places: the synchroniser and previous-level registers, the captured configuration, and the count itself. A wrong previous level shows up as a spurious or missing step on `count` exactly two clocks after the offending input change. A wrong captured mode or edge setting shows up at the very next encoder transition as a step in the wrong direction or a step that should not occur. A count that is off by one stays off by one, because nothing resynchronises it. Comparing against a reference model on every clock therefore catches such a fault at the first clock where it becomes visible.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   localparam logic [1:0] EDGE_RISE = 2'b00;
   localparam logic [1:0] EDGE_FALL = 2'b01;

   typedef struct packed {
      logic up;
      logic dn;
      logic bad;
   } step_t;

   function automatic logic edge_counts(input logic new_level, input logic [1:0] sel);
      if (new_level) return (sel != EDGE_FALL);
      else           return (sel != EDGE_RISE);
   endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[i] <= '0;
            else if (i == 0) chain[i] <= d;
            else             chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       armed,
   input  logic       quad,
   input  logic [1:0] edge_sel,
   input  logic [1:0] cur,   // bit0 = A, bit1 = B
   input  logic [1:0] old,
   output step_t      step
);
   logic moved_a, moved_b;
   assign moved_a = cur[0] ^ old[0];
   assign moved_b = cur[1] ^ old[1];

   always_comb begin
      step = '0;
      if (armed) begin
         if (!quad) begin
            step.up = moved_a && edge_counts(cur[0], edge_sel);
         end else if (moved_a && moved_b) begin
            step.bad = 1'b1;
         end else if (moved_a && edge_counts(cur[0], edge_sel)) begin
            case ({cur[0], cur[1]})
               2'b11, 2'b00: step.dn = 1'b1;
               default:      step.up = 1'b1;
            endcase
         end else if (moved_b && edge_counts(cur[1], edge_sel)) begin
            case ({cur[1], cur[0]})
               2'b11, 2'b00: step.up = 1'b1;
               default:      step.dn = 1'b1;
            endcase
         end
      end
   end

   // R8
   step_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step.up, step.dn, step.bad}));
   // R2
   simple_never_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !quad |-> !step.dn && !step.bad);
endmodule

// File: rtl/qenc_count.sv
module qenc_count
   import qenc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  step_t            step,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up,
   output logic             err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b0;
         err    <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         if (step.bad) err <= 1'b1;
         if (step.up) begin
            cnt    <= (cnt >= limit) ? '0 : cnt + 1'b1;
            dir_up <= 1'b1;
         end else if (step.dn) begin
            cnt    <= (cnt == '0) ? limit : cnt - 1'b1;
            dir_up <= 1'b0;
         end
      end
   end

   // R7
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step.up && cnt >= limit) |=> (cnt == '0));
   // R7
   wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step.dn && cnt == '0) |=> (cnt == $past(limit)));
   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   // R9
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0) && !err);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             clear,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             cfg_quad,
   input  logic [1:0]       cfg_edge,
   input  logic [CNT_W-1:0] cfg_preset,
   output logic [CNT_W-1:0] count,
   output logic             dir_up,
   output logic             err_flag
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("qenc_counter needs CNT_W of at least 2");
      end
   endgenerate

   logic [1:0]       lvl_now, lvl_prev;
   logic             en_q, armed;
   logic             quad_q;
   logic [1:0]       edge_q;
   logic [CNT_W-1:0] limit_q;
   step_t            step;

   qenc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({enc_b, enc_a}), .q(lvl_now));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         en_q     <= 1'b0;
         quad_q   <= 1'b0;
         edge_q   <= EDGE_RISE;
         limit_q  <= '0;
      end else begin
         lvl_prev <= lvl_now;
         en_q     <= enable;
         if (!enable) begin
            quad_q  <= cfg_quad;
            edge_q  <= cfg_edge;
            limit_q <= cfg_preset;
         end
      end
   end

   assign armed = enable && en_q;

   qenc_decode u_decode (
      .clk(clk), .rst_n(rst_n), .armed(armed), .quad(quad_q),
      .edge_sel(edge_q), .cur(lvl_now), .old(lvl_prev), .step(step));

   qenc_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(clear), .step(step), .limit(limit_q),
      .cnt(count), .dir_up(dir_up), .err(err_flag));

   // R11
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !clear) |=> $stable(count));
   // R10
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(limit_q) && $stable(edge_q) && $stable(quad_q));
endmodule

// File: tb/qenc_counter_test.sv
`timescale 1ns/1ps
module qenc_counter_test;
   localparam int W = 16;

   logic clk = 0, rst_n = 0, enable = 0, clear = 0, enc_a = 0, enc_b = 0, cfg_quad = 0;
   logic [1:0]   cfg_edge = 2'b00;
   logic [W-1:0] cfg_preset = '0;
   logic [W-1:0] count;
   logic         dir_up, err_flag;

   qenc_counter #(.CNT_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
      .enc_a(enc_a), .enc_b(enc_b), .cfg_quad(cfg_quad), .cfg_edge(cfg_edge),
      .cfg_preset(cfg_preset), .count(count), .dir_up(dir_up), .err_flag(err_flag));

   always #2 clk = ~clk;

   int checks = 0, fails = 0;
   string phase = "R1";
   bit done = 0;

   // reference model: input samples of the last three edges, newest first
   bit [1:0] hist[$] = '{2'b00, 2'b00, 2'b00};
   int m_cnt = 0, m_edge = 0, m_preset = 0;
   bit m_dir = 0, m_err = 0, m_enq = 0, m_quad = 0;

   function automatic bit lvl_ok(bit v, int sel);
      return v ? (sel != 1) : (sel != 0);
   endfunction

   task automatic m_step(bit up);
      if (up) begin m_cnt = (m_cnt >= m_preset) ? 0 : m_cnt + 1; m_dir = 1; end
      else    begin m_cnt = (m_cnt == 0) ? m_preset : m_cnt - 1; m_dir = 0; end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{2'b00, 2'b00, 2'b00};
         m_cnt = 0; m_dir = 0; m_err = 0; m_enq = 0; m_quad = 0; m_edge = 0; m_preset = 0;
      end else begin
         bit [1:0] cur, old;
         bit ca, cb, da, db;
         cur = hist[1]; old = hist[2];
         ca = cur[0]; cb = cur[1];
         da = cur[0] != old[0]; db = cur[1] != old[1];
         if (clear) begin
            m_cnt = 0; m_err = 0;
         end else if (enable && m_enq) begin
            if (!m_quad) begin
               if (da && lvl_ok(ca, m_edge)) m_step(1);
            end else if (da && db) m_err = 1;
            else if (da && lvl_ok(ca, m_edge)) m_step(ca ^ cb);
            else if (db && lvl_ok(cb, m_edge)) m_step(!(ca ^ cb));
         end
         m_enq = enable;
         if (!enable) begin m_quad = cfg_quad; m_edge = cfg_edge; m_preset = cfg_preset; end
         void'(hist.pop_back());
         hist.push_front({enc_b, enc_a});
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (count != m_cnt[W-1:0] || dir_up != m_dir || err_flag != m_err) begin
            fails++;
            $display("FAIL %s cycle model: count/dir/err = %0d/%0d/%0d expected %0d/%0d/%0d",
                     phase, count, dir_up, err_flag, m_cnt, m_dir, m_err);
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(bit a, bit b);
      @(negedge clk); enc_a = a; enc_b = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_a();
      drive(1, enc_b);
      drive(0, enc_b);
   endtask

   task automatic configure(bit quad, bit [1:0] sel, int lim);
      @(negedge clk); enable = 0;
      @(negedge clk); cfg_quad = quad; cfg_edge = sel; cfg_preset = lim[W-1:0];
      @(negedge clk); enable = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk); clear = 1;
      @(negedge clk); clear = 0;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 count", count, 0); chk("R1 dir", dir_up, 0); chk("R1 err", err_flag, 0);

      phase = "R2";
      configure(0, 2'b00, 5);
      repeat (3) pulse_a();
      chk("R2 count", count, 3); chk("R2 dir", dir_up, 1);
      drive(0, 1); drive(0, 0);
      chk("R2 B ignored", count, 3);

      phase = "R3";
      configure(0, 2'b01, 5);
      repeat (2) pulse_a();
      chk("R3 falling", count, 5);
      phase = "R7";
      pulse_a();
      chk("R7 wrap up", count, 0);
      phase = "R3";
      configure(0, 2'b10, 5);
      pulse_a();
      chk("R3 both", count, 2);

      phase = "R9";
      do_clear();
      chk("R9 clear", count, 0);

      phase = "R4";
      configure(1, 2'b00, 5);
      drive(1, 0); drive(1, 1); drive(0, 1); drive(0, 0);
      chk("R4 forward", count, 2); chk("R13 dir up", dir_up, 1);
      drive(0, 1); drive(1, 1);
      chk("R4 reverse", count, 0); chk("R13 dir down", dir_up, 0);
      drive(1, 0); drive(0, 0);
      phase = "R7";
      drive(0, 1);
      chk("R7 wrap down", count, 5);
      drive(0, 0);

      phase = "R5";
      do_clear();
      configure(1, 2'b01, 5);
      drive(0, 1); drive(1, 1); drive(0, 1); drive(0, 0);
      chk("R5 forward", count, 2);
      drive(1, 0); drive(0, 0);
      chk("R5 reverse", count, 1); chk("R5 dir", dir_up, 0);

      phase = "R6";
      configure(1, 2'b10, 100);
      drive(1, 0); drive(1, 1); drive(0, 1); drive(0, 0);
      chk("R6 four steps", count, 5);

      phase = "R10";
      @(negedge clk); cfg_preset = 3; cfg_edge = 2'b00;
      drive(1, 0);
      chk("R10 limit kept", count, 6);
      drive(0, 0);
      chk("R10 edge kept", count, 5);
      @(negedge clk); cfg_preset = 100; cfg_edge = 2'b10;

      phase = "R8";
      drive(1, 1);
      chk("R8 count held", count, 5); chk("R8 err set", err_flag, 1);
      drive(0, 1);
      chk("R8 still counts", count, 6); chk("R8 sticky", err_flag, 1);
      phase = "R9";
      do_clear();
      chk("R9 err cleared", err_flag, 0); chk("R9 count", count, 0);

      phase = "R11";
      @(negedge clk); enable = 0;
      drive(1, 0);
      chk("R11 disabled", count, 0);
      @(negedge clk); enable = 1;
      repeat (4) @(negedge clk);
      chk("R11 enable no false edge", count, 0);

      phase = "R12";
      @(negedge clk); enc_b = 1;
      @(negedge clk); chk("R12 edge k", count, 0);
      @(negedge clk); chk("R12 edge k+1", count, 0);
      @(negedge clk); chk("R12 edge k+2", count, 1);

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule